// File: doc/BRIEF.md
# Streaming Online Softmax Accumulator

This block forms one output row of attention in a single pass. It receives a stream of beats. Each beat carries one score and a value vector of `D` elements. Beats are grouped into blocks of at most `BLK` beats. For every block the block finds the largest score and compares it with the stored running maximum. If the maximum rises, the block multiplies the stored normalizer and the stored unnormalized output vector by exp(old max − new max), which never exceeds one. It then adds in each beat's weight exp(score − new max) and the weight times that beat's value vector. The full score row is never kept. Only the beats of the current block are buffered.

When the block that closes the row has been folded in, the block divides each accumulator element by the normalizer. It uses a restoring divider and handles one element at a time. Each quotient is presented on a valid/ready output, and the element `D−1` is marked as last. The exponential uses base 2. The argument is scaled by log2 e. The integer part becomes a right shift. The fractional part comes from an eight-segment piecewise-linear table. Arguments that would shift the weight below the LSB give zero.

Scores, values and outputs are signed two's-complement with `SF` fraction bits. The default is 16-bit Q7.8. Weights and the rescale factor are unsigned with `EF` fraction bits, so exp(0) equals 2^EF exactly.

Top module: `osr_accum`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and out_last is 0.
- R2: In the cycle after a beat with in_blk_end=1 is accepted, in_ready is 0. It stays 0 until that block has been folded in. A beat offered while in_ready is 0 is not taken.
- R3: For a row made of one block, each output element (signed, SF=8 fraction bits) equals Σ exp(s−m)·v / Σ exp(s−m), where m is the largest score of the row. The result must agree within 20 LSB. Scores and values are signed with 8 fraction bits.
- R4: For a row of several blocks whose maximum rises from block to block, the output matches the same two-pass result within 20 LSB. The state is rescaled by exp(old max − new max) ≤ 1, and on the first block of a row the factor is forced to zero.
- R5: The result for a given beat sequence is the same two-pass result within 20 LSB, whatever block length from 1 to BLK is used to split it.
- R6: A score below the running maximum by more than (EF+1)/log2 e gets weight zero, and a score equal to the maximum gets a weight of exactly one. So when one score dominates by 12.0 or more, every output element equals that beat's value exactly.
- R7: When all scores of a row are equal, each output element is exactly the mean of the values, provided that mean is representable.
- R8: Each row yields exactly D output beats in element order 0 to D−1. out_last is 1 on element D−1 only.
- R9: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values.
- R10: A beat with in_blk_first=1 restarts the block buffer. Beats accepted earlier in the unfinished block are discarded.
- R11: Once element D−1 has been accepted, the running maximum, normalizer and accumulators return to their start values (most negative, zero, zero). The next row's result does not depend on earlier rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept a beat |
| in_score | input | SW | Signed score, SF fraction bits |
| in_value | input | D*VW | Value vector, element i at bits [i*VW +: VW], signed, SF fraction bits |
| in_blk_first | input | 1 | Beat opens a block |
| in_blk_end | input | 1 | Beat closes a block |
| in_row_end | input | 1 | Beat closes the row (only with in_blk_end) |
| out_valid | output | 1 | Output element valid |
| out_ready | input | 1 | Consumer takes the element |
| out_data | output | VW | Normalized output element, signed, SF fraction bits |
| out_last | output | 1 | Element D−1 of the row |

## Verification
The only fixed latency checked is for in_ready. It is sampled on the falling edge right after the rising edge that takes a block-closing beat, and it must be 0 there. A block then stays busy for one rescale cycle plus one cycle per buffered beat. Each output element appears one load cycle plus ACW divider cycles after the previous one is taken. The bench does not predict these counts. It drives and samples on falling edges and polls the handshakes, so each result is compared on the cycle its handshake completes. It throttles out_ready in a fixed pattern, so the hold behaviour is exercised on many elements. Expected outputs come from a two-pass floating-point softmax of the same fixed-point scores and values.

// File: rtl/osr_pkg.sv
package osr_pkg;
  typedef enum logic [2:0] {
    ST_FILL,
    ST_SCALE,
    ST_ACCUM,
    ST_DLOAD,
    ST_DRUN,
    ST_SEND
  } osr_state_e;

  // log2(e) with 14 fraction bits
  localparam int LOG2E_Q14 = 23637;
endpackage

// File: rtl/osr_exp2.sv
// Combinational exp(x) for x <= 0, result unsigned with EF fraction bits.
module osr_exp2 #(
  parameter int XW = 17,
  parameter int SF = 8,
  parameter int EF = 15
) (
  input  logic signed [XW-1:0] x_i,
  output logic [EF:0]          w_o
);
  localparam int PW = XW + 16;
  localparam int RB = SF - 3;
  // 2^(-k/8), k = 0..8, with 15 fraction bits
  localparam logic [15:0] TBL [0:8] = '{16'd32768, 16'd30048, 16'd27554,
    16'd25268, 16'd23170, 16'd21247, 16'd19484, 16'd17867, 16'd16384};

  logic [PW-1:0] mag, prod, y, ip;
  logic [SF-1:0] fr;
  logic [2:0]    seg;
  logic [15:0]   hi, lo, val;
  logic [31:0]   dp;
  logic [4:0]    sh;

  always_comb begin
    mag  = PW'(-x_i);
    prod = mag * PW'(osr_pkg::LOG2E_Q14);
    y    = prod >> 14;
    ip   = y >> SF;
    fr   = y[SF-1:0];
    seg  = fr[SF-1 -: 3];
    hi   = TBL[4'(seg)];
    lo   = TBL[4'(seg) + 4'd1];
    dp   = (32'(hi - lo) * 32'(fr[RB-1:0])) >> RB;
    val  = hi - dp[15:0];
    sh   = 5'(ip) + 5'(15 - EF);
    w_o  = (ip > PW'(EF)) ? '0 : (EF+1)'(val >> sh);
  end
endmodule

// File: rtl/osr_rdiv.sv
// Restoring unsigned divider, one quotient bit per cycle.
module osr_rdiv #(
  parameter int NW = 48,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [NW-1:0] quo
);
  localparam int CW = $clog2(NW + 1);

  logic [DW-1:0] rem, den_q;
  logic [DW:0]   trial;
  logic [CW-1:0] cnt;
  logic          busy;

  always_comb trial = {rem, quo[NW-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0; den_q <= '0; quo <= '0; cnt <= '0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem <= '0; quo <= num; den_q <= den; cnt <= CW'(NW); busy <= 1'b1;
      end else if (busy) begin
        if (trial >= {1'b0, den_q}) begin
          rem <= DW'(trial - {1'b0, den_q});
          quo <= {quo[NW-2:0], 1'b1};
        end else begin
          rem <= trial[DW-1:0];
          quo <= {quo[NW-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_DEN_NONZERO: assert property (@(posedge clk) disable iff (rst) start |-> den != '0); // R3
  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst) start |-> !busy); // R3
endmodule

// File: rtl/osr_accum.sv
module osr_accum #(
  parameter int D    = 4,
  parameter int BLK  = 4,
  parameter int SW   = 16,
  parameter int SF   = 8,
  parameter int VW   = 16,
  parameter int EF   = 15,
  parameter int SUMW = 32,
  parameter int ACW  = 48
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [SW-1:0]   in_score,
  input  logic [D*VW-1:0] in_value,
  input  logic            in_blk_first,
  input  logic            in_blk_end,
  input  logic            in_row_end,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [VW-1:0]   out_data,
  output logic            out_last
);
  import osr_pkg::*;

  localparam int EW = EF + 1;
  localparam int XW = SW + 1;
  localparam int PW = ACW + EW + 1;
  localparam int SP = SUMW + EW;
  localparam int IW = (BLK > 1) ? $clog2(BLK) : 1;
  localparam int KW = (D > 1) ? $clog2(D) : 1;
  localparam logic [EW-1:0] ONE = EW'(1) << EF;
  localparam logic signed [SW-1:0] SMIN = {1'b1, {(SW-1){1'b0}}};

  osr_state_e st;
  logic signed [SW-1:0]  run_max, blk_max, new_max, mx_this, sc_in;
  logic                  first, row_end_q, neg;
  logic [SUMW-1:0]       sum;
  logic signed [ACW-1:0] acc [D];
  logic signed [SW-1:0]  buf_s [BLK];
  logic [D*VW-1:0]       buf_v [BLK];
  logic [IW-1:0]         cnt, idx, klast, k;
  logic [KW-1:0]         e;
  logic signed [XW-1:0]  x_arg;
  logic [EW-1:0]         w_out, alpha;
  logic signed [PW-1:0]  sc_p [D];
  logic signed [ACW-1:0] term [D];
  logic [SP-1:0]         sum_p;
  logic [ACW-1:0]        dv_num, dv_quo;
  logic                  dv_done;
  logic [VW-1:0]         q_mag;

  assign in_ready = (st == ST_FILL);
  assign sc_in    = in_score;
  assign idx      = in_blk_first ? '0 : cnt;
  assign mx_this  = (idx == '0 || sc_in > blk_max) ? sc_in : blk_max;

  always_comb begin
    if (st == ST_SCALE) x_arg = XW'(run_max) - XW'(new_max);
    else                x_arg = XW'(buf_s[k]) - XW'(run_max);
  end

  osr_exp2 #(.XW(XW), .SF(SF), .EF(EF)) u_exp (.x_i(x_arg), .w_o(w_out));

  assign alpha = first ? '0 : w_out;
  assign sum_p = SP'(sum) * SP'(alpha);

  always_comb begin
    for (int i = 0; i < D; i++) begin
      logic signed [PW-1:0]  a_ext, f_ext;
      logic signed [ACW-1:0] w_ext, v_ext;
      a_ext   = PW'(acc[i]);
      f_ext   = PW'({1'b0, alpha});
      sc_p[i] = a_ext * f_ext;
      w_ext   = ACW'({1'b0, w_out});
      v_ext   = ACW'($signed(buf_v[k][i*VW +: VW]));
      term[i] = w_ext * v_ext;
    end
  end

  assign dv_num = acc[e][ACW-1] ? ACW'(-acc[e]) : ACW'(acc[e]);
  assign q_mag  = (|dv_quo[ACW-1:VW-1]) ? {1'b0, {(VW-1){1'b1}}} : dv_quo[VW-1:0];

  osr_rdiv #(.NW(ACW), .DW(SUMW)) u_div (
    .clk(clk), .rst(rst), .start(st == ST_DLOAD), .num(dv_num), .den(sum),
    .done(dv_done), .quo(dv_quo));

  // block buffer: plain storage, no reset
  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      buf_s[idx] <= sc_in;
      buf_v[idx] <= in_value;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_FILL; first <= 1'b1; run_max <= SMIN; blk_max <= SMIN; new_max <= SMIN;
      sum <= '0; cnt <= '0; klast <= '0; k <= '0; e <= '0; row_end_q <= 1'b0; neg <= 1'b0;
      out_valid <= 1'b0; out_last <= 1'b0; out_data <= '0;
      for (int i = 0; i < D; i++) acc[i] <= '0;
    end else begin
      case (st)
        ST_FILL: if (in_valid) begin
          blk_max <= mx_this;
          if (in_blk_end) begin
            new_max   <= (first || mx_this > run_max) ? mx_this : run_max;
            klast     <= idx;
            row_end_q <= in_row_end;
            cnt       <= '0;
            st        <= ST_SCALE;
          end else begin
            cnt <= idx + 1'b1;
          end
        end
        ST_SCALE: begin
          sum <= SUMW'(sum_p >> EF);
          for (int i = 0; i < D; i++) acc[i] <= ACW'(sc_p[i] >>> EF);
          run_max <= new_max;
          first   <= 1'b0;
          k       <= '0;
          st      <= ST_ACCUM;
        end
        ST_ACCUM: begin
          sum <= sum + SUMW'(w_out);
          for (int i = 0; i < D; i++) acc[i] <= acc[i] + term[i];
          k <= k + 1'b1;
          if (k == klast) begin
            e  <= '0;
            st <= row_end_q ? ST_DLOAD : ST_FILL;
          end
        end
        ST_DLOAD: begin
          neg <= acc[e][ACW-1];
          st  <= ST_DRUN;
        end
        ST_DRUN: if (dv_done) begin
          out_data  <= neg ? VW'(-q_mag) : q_mag;
          out_valid <= 1'b1;
          out_last  <= (e == KW'(D - 1));
          st        <= ST_SEND;
        end
        ST_SEND: if (out_ready) begin
          out_valid <= 1'b0;
          out_last  <= 1'b0;
          if (e == KW'(D - 1)) begin
            first <= 1'b1; run_max <= SMIN; sum <= '0;
            for (int i = 0; i < D; i++) acc[i] <= '0;
            st <= ST_FILL;
          end else begin
            e  <= e + 1'b1;
            st <= ST_DLOAD;
          end
        end
        default: st <= ST_FILL;
      endcase
    end
  end

  AST_ARG_NONPOS: assert property (@(posedge clk) disable iff (rst) (st == ST_SCALE || st == ST_ACCUM) |-> x_arg <= 0); // R4
  AST_ALPHA_LE_ONE: assert property (@(posedge clk) disable iff (rst) (st == ST_SCALE) |-> alpha <= ONE); // R4
  AST_MAX_MONO: assert property (@(posedge clk) disable iff (rst) (st == ST_SCALE) |-> new_max >= run_max); // R4
  AST_SUM_ATLEAST_ONE: assert property (@(posedge clk) disable iff (rst) (st == ST_DLOAD) |-> sum >= SUMW'(ONE)); // R6
  AST_READY_DROP: assert property (@(posedge clk) disable iff (rst) (in_valid && in_ready && in_blk_end) |=> !in_ready); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last)); // R9
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (rst) out_last |-> out_valid); // R8
endmodule

// File: tb/osr_accum_tb.sv
module osr_accum_tb;
  localparam int D = 4;
  localparam int VW = 16;
  localparam int TOL = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_blk_first = 1'b0, in_blk_end = 1'b0, in_row_end = 1'b0;
  logic in_ready, out_valid, out_last;
  logic out_ready = 1'b1;
  logic [15:0] in_score = '0;
  logic [D*VW-1:0] in_value = '0;
  logic [VW-1:0] out_data;

  int checks = 0, fails = 0, tick = 0;
  int sc [0:15];
  int vv [0:15][0:3];
  logic [31:0] lf = 32'h1234_5679;

  always #5 clk = ~clk;

  osr_accum u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_score(in_score), .in_value(in_value), .in_blk_first(in_blk_first),
    .in_blk_end(in_blk_end), .in_row_end(in_row_end), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last));

  task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int rnd(input int r);
    lf = lf ^ (lf << 13);
    lf = lf ^ (lf >> 17);
    lf = lf ^ (lf << 5);
    return int'(lf % (2 * r + 1)) - r;
  endfunction

  // drive one beat starting at a falling edge; returns at the falling edge after acceptance
  task automatic drive_beat(input int s, input int j, input bit bf, input bit be, input bit re);
    in_score = 16'(s);
    for (int i = 0; i < D; i++) in_value[i*VW +: VW] = VW'(vv[j][i]);
    in_blk_first = bf; in_blk_end = be; in_row_end = re; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (be) check(in_ready == 1'b0, "R2", "in_ready after block end", int'(in_ready), 0);
  endtask

  task automatic run_row(input int n, input int bl, input string rq, input int tol, input bit stray);
    real m, l, o;
    int expv [0:3];
    int got, e, held;
    bit stalled;
    m = sc[0];
    for (int j = 1; j < n; j++) if (sc[j] > m) m = sc[j];
    l = 0.0;
    for (int j = 0; j < n; j++) l += $exp((sc[j] - m) / 256.0);
    for (int i = 0; i < D; i++) begin
      o = 0.0;
      for (int j = 0; j < n; j++) o += $exp((sc[j] - m) / 256.0) * vv[j][i];
      o = o / l;
      expv[i] = $rtoi(o + ((o >= 0.0) ? 0.5 : -0.5));
    end
    // R10: a discarded beat with a huge score, then the real block restarts
    if (stray) drive_beat(32000, 15, 1'b1, 1'b0, 1'b0);
    for (int j = 0; j < n; j++)
      drive_beat(sc[j], j, (j % bl) == 0, ((j % bl) == bl - 1) || (j == n - 1), j == n - 1);
    e = 0; stalled = 1'b0; held = 0;
    while (e < D) begin
      @(negedge clk);
      out_ready = ((tick++ % 3) != 2);
      if (out_valid) begin
        if (stalled) check(int'(out_data) == held, "R9", "held data", int'(out_data), held);
        if (out_ready) begin
          got = int'($signed(out_data));
          check(got - expv[e] <= tol && expv[e] - got <= tol, rq, $sformatf("element %0d", e), got, expv[e]);
          check(out_last == (e == D - 1), "R8", $sformatf("out_last at element %0d", e), int'(out_last), int'(e == D - 1));
          e++; stalled = 1'b0;
        end else begin
          stalled = 1'b1; held = int'(out_data);
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int j = 0; j < 16; j++) for (int i = 0; i < D; i++) vv[j][i] = 700;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(in_ready == 1'b1, "R1", "in_ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
    check(out_last == 1'b0, "R1", "out_last", int'(out_last), 0);

    // R7 equal scores give the exact mean
    for (int j = 0; j < 4; j++) begin
      sc[j] = 300;
      for (int i = 0; i < D; i++) vv[j][i] = 256 * j + 64 * i;
    end
    run_row(4, 4, "R7", 0, 1'b0);

    // R3 single-block rows of each length
    for (int n = 1; n <= 4; n++) begin
      for (int j = 0; j < n; j++) begin
        sc[j] = rnd(1024);
        for (int i = 0; i < D; i++) vv[j][i] = rnd(768);
      end
      run_row(n, 4, "R3", TOL, 1'b0);
    end

    // R4 rising maximum across blocks
    for (int j = 0; j < 12; j++) begin
      sc[j] = -2048 + 400 * j;
      for (int i = 0; i < D; i++) vv[j][i] = rnd(768);
    end
    run_row(12, 3, "R4", TOL, 1'b0);

    // R5 same beats, every block length
    for (int j = 0; j < 12; j++) begin
      sc[j] = rnd(2048);
      for (int i = 0; i < D; i++) vv[j][i] = rnd(768);
    end
    for (int bl = 1; bl <= 4; bl++) run_row(12, bl, "R5", TOL, 1'b0);

    // R6 dominant score flushes every other weight
    for (int j = 0; j < 6; j++) begin
      sc[j] = (j == 0) ? 5120 : rnd(2048);
      for (int i = 0; i < D; i++) vv[j][i] = rnd(768);
    end
    run_row(6, 2, "R6", 0, 1'b0);
    sc[0] = 0; sc[4] = 5120;
    run_row(6, 2, "R6", 0, 1'b0);

    // R10 block-first restarts the buffer
    for (int i = 0; i < D; i++) vv[15][i] = 30000;
    for (int j = 0; j < 3; j++) begin
      sc[j] = rnd(1024);
      for (int i = 0; i < D; i++) vv[j][i] = rnd(768);
    end
    run_row(3, 3, "R10", TOL, 1'b1);

    // R11 sweep of back-to-back rows
    for (int t = 0; t < 60; t++) begin
      int n, bl;
      n = 1 + t % 12;
      bl = 1 + (t / 12) % 4;
      for (int j = 0; j < n; j++) begin
        sc[j] = rnd(4096);
        for (int i = 0; i < D; i++) vv[j][i] = rnd(768);
      end
      run_row(n, bl, "R11", TOL, 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule